// File: doc/BRIEF.md
# Block-Write DMA Engine

This engine copies a block of words from a device-side source into memory while acting as a bus master. Software programs a start word address and a word count through a small register-write port. A write to the control register with the go bit set starts a transfer, and the same write selects its mode. The engine then raises a bus request and waits for a grant. It drives memory writes only while the grant is present.

There are two ways of using the bus. In burst mode the request stays up from start to finish, so the whole block moves under one grant. In single-word mode the engine gives the bus back after every word and asks for it again before the next one. This lets the primary master use the bus between words.

Device words pass straight through to the memory write port, and each accepted write pops one word from the device. After the last word the engine drops its request and raises an interrupt. The interrupt stays high until software clears it.

Top module: `dma_blk_engine`

## Requirements
- R1: `mem_valid` is high only in cycles in which both `bus_req` and `bus_gnt` are high.
- R2: A memory write completes in a cycle with `mem_valid` and `mem_ready` both high, and `dev_pop` is high in exactly those cycles. The first write goes to the loaded start address. Each completed write advances the address by one, modulo 2^ADDR_W. `mem_data` carries the current device word, and the address is held while a write is stalled.
- R3: Register map on `cfg_sel`:
  - 0 is the start address (low ADDR_W bits).
  - 1 is the word count (low CNT_W bits).
  - 2 is control: bit 0 is go, and bit 1 selects single-word mode when 1 and burst mode when 0.
  - 3 is interrupt clear (bit 0).

  After an accepted go, `bus_req` is high in the next cycle. In burst mode it stays high without a break until the last word is written.
- R4: In single-word mode `bus_req` is low in the cycle after each completed write, and it rises again for the next word. A block of N words therefore shows N rising edges of `bus_req`.
- R5: In the cycle after the last word is written, `bus_req` is low and `irq` is high.
- R6: Once high, `irq` stays high until a write to register 3 with bit 0 set clears it. A write to register 3 with bit 0 clear has no effect.
- R7: A go write while a transfer is in progress is ignored. Register writes made during a transfer do not alter the address sequence or the word count of that transfer.
- R8: A go with a word count of zero sets `irq` in the next cycle and never raises `bus_req`.
- R9: After reset, `bus_req`, `mem_valid` and `irq` are low.
- R10: If `bus_gnt` is withdrawn during a burst, writes pause while the request stays up. Writing resumes when the grant returns, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_valid | output | 1 | Memory write valid |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| dev_data | input | DATA_W | Current device word |
| dev_valid | input | 1 | Device word is available |
| dev_pop | output | 1 | Device word consumed |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with ADDR_W=6, CNT_W=4 and DATA_W=16. With a 6-bit address, a block that starts at word 62 crosses the top of the address space and wraps to 0 inside a short run. The 4-bit count lets the bench exercise the largest legal block of 15 words as well as the zero-count case. Device gaps, memory stalls and withdrawn grants are combined with both bus modes, so pauses land at every point in the handshake.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_GAP
    } dma_state_e;

    typedef struct packed {
        dma_state_e state;
        logic       single;
        logic       irq;
    } dma_ctl_t;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_IRQ   = 2'd3;

    localparam int CTRL_GO_BIT     = 0;
    localparam int CTRL_SINGLE_BIT = 1;
    localparam int IRQ_CLR_BIT     = 0;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  count,
    output logic              go,
    output logic              go_single,
    output logic              irq_clr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  count;
    } cfg_t;

    cfg_t r_d, r_q;
    logic wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        r_d = r_q;
        if (we && sel == SEL_BASE)  r_d.base  = wdata[ADDR_W-1:0];
        if (we && sel == SEL_COUNT) r_d.count = wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base      = r_q.base;
    assign count     = r_q.count;
    assign go        = we && (sel == SEL_CTRL) && wdata[CTRL_GO_BIT];
    assign go_single = wdata[CTRL_SINGLE_BIT];
    assign irq_clr   = we && (sel == SEL_IRQ) && wdata[IRQ_CLR_BIT];

endmodule

// File: rtl/dma_walker.sv
module dma_walker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.addr = load_addr;
            w_d.rem  = load_cnt;
        end else if (step) begin
            w_d.addr = w_q.addr + ADDR_ONE;
            w_d.rem  = w_q.rem - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign addr = w_q.addr;
    assign last = (w_q.rem == CNT_ONE);

endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
    import dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_valid,
    output logic              dev_pop,
    output logic              irq
);

    dma_ctl_t c_d, c_q;

    logic [ADDR_W-1:0] cfg_base;
    logic [CNT_W-1:0]  cfg_count;
    logic              go, go_single, irq_clr;
    logic              busy, go_ok, wr_done, last;

    dma_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .base      (cfg_base),
        .count     (cfg_count),
        .go        (go),
        .go_single (go_single),
        .irq_clr   (irq_clr)
    );

    dma_walker #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_ok),
        .load_addr (cfg_base),
        .load_cnt  (cfg_count),
        .step      (wr_done),
        .addr      (mem_addr),
        .last      (last)
    );

    assign busy  = (c_q.state != ST_IDLE);
    assign go_ok = go && !busy && (cfg_count != '0);

    always_comb begin
        c_d = c_q;
        if (irq_clr) c_d.irq = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (go) begin
                    if (cfg_count == '0) begin
                        c_d.irq = 1'b1;
                    end else begin
                        c_d.state  = ST_REQ;
                        c_d.single = go_single;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) c_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (wr_done) begin
                    if (last) begin
                        c_d.state = ST_IDLE;
                        c_d.irq   = 1'b1;
                    end else if (c_q.single) begin
                        c_d.state = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                c_d.state = ST_REQ;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, single: 1'b0, irq: 1'b0};
        else        c_q <= c_d;
    end

    assign bus_req   = (c_q.state == ST_REQ) || (c_q.state == ST_XFER);
    assign mem_valid = (c_q.state == ST_XFER) && bus_gnt && dev_valid;
    assign wr_done   = mem_valid && mem_ready;
    assign dev_pop   = wr_done;
    assign mem_data  = dev_data;
    assign irq       = c_q.irq;

endmodule

// File: rtl/dma_blk_checker.sv
module dma_blk_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_wr,
    input logic              go_wr,
    input logic              count_zero,
    input logic              busy,
    input logic              single,
    input logic              last,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq
);

    assert_valid_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) ##1 mem_valid |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));

    assert_burst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !single && !(mem_valid && mem_ready && last)) |=> bus_req);

    assert_single_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && single) |=> !bus_req);

    assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && last) |=> (!bus_req && irq));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !busy && count_zero) |=> (!bus_req && irq));

endmodule

bind dma_blk_engine dma_blk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_wr     (cfg_we && cfg_sel == 2'd3 && cfg_wdata[0]),
    .go_wr      (cfg_we && cfg_sel == 2'd2 && cfg_wdata[0]),
    .count_zero (cfg_count == '0),
    .busy       (busy),
    .single     (c_q.single),
    .last       (last),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .irq        (irq)
);

// File: tb/sim_dma_blk_engine.sv
`timescale 1ns/1ps
module sim_dma_blk_engine;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int CW = 4;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic bus_req, bus_gnt = 1'b0;
    logic mem_valid, mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data, dev_data;
    logic dev_valid = 1'b0, dev_pop, irq;

    always #10 clk = ~clk;

    dma_blk_engine #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .dev_data(dev_data), .dev_valid(dev_valid),
        .dev_pop(dev_pop), .irq(irq)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;

    item_t sb[$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0, dev_idx = 0, exp_idx = 0;
    int req_rises = 0, r1_viol = 0, gnt_gaps = 0;
    logic req_prev = 1'b0;
    logic k_stall = 0, k_gaps = 0, k_gdrop = 0;

    function automatic logic [DW-1:0] dev_word(int k);
        return DW'(16'hA500 ^ (k * 263));
    endfunction

    assign dev_data = dev_word(dev_idx);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // environment: arbiter, memory and device pacing
    always @(posedge clk) begin
        #1;
        cyc++;
        bus_gnt   = bus_req && !(k_gdrop && (cyc % 7 >= 4));
        mem_ready = !(k_stall && (cyc % 4 == 1));
        dev_valid = !(k_gaps && (cyc % 3 == 0));
        if (cyc == LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && !(bus_req && bus_gnt)) r1_viol++;
            if (bus_req && bus_gnt == 1'b0) gnt_gaps++;
            if (bus_req && !req_prev) req_rises++;
            req_prev = bus_req;
            if (mem_valid && mem_ready) begin
                chk(dev_pop, "R2", "dev_pop on write", int'(dev_pop), 1);
                if (sb.size() == 0) begin
                    chk(0, "R2", "unexpected write addr", int'(mem_addr), -1);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    chk(mem_addr == e.a, "R2", "write address", int'(mem_addr), int'(e.a));
                    chk(mem_data == e.d, "R2", "write data", int'(mem_data), int'(e.d));
                end
                dev_idx++;
            end
        end
    end

    task automatic cfg_write(logic [1:0] s, logic [DW-1:0] v);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic run_block(int base, int count, bit single, bit stall,
                             bit gaps, bit gdrop, bit poke, string tag);
        int waited;
        k_stall = stall; k_gaps = gaps; k_gdrop = gdrop;
        cfg_write(2'd3, 16'h1);
        cfg_write(2'd0, DW'(base));
        cfg_write(2'd1, DW'(count));
        for (int i = 0; i < count; i++) begin
            item_t e;
            e.a = AW'(base + i);
            e.d = dev_word(exp_idx);
            exp_idx++;
            sb.push_back(e);
        end
        req_rises = 0; r1_viol = 0; gnt_gaps = 0;
        cfg_write(2'd2, {14'd0, single, 1'b1});
        @(negedge clk);
        chk(bus_req, "R3", {tag, " request after go"}, int'(bus_req), 1);
        if (poke) begin
            // R7: restart and new base while busy must change nothing
            cfg_write(2'd0, 16'd40);
            cfg_write(2'd1, 16'd2);
            cfg_write(2'd2, 16'h1);
        end
        waited = 0;
        while (!irq && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(irq, "R5", {tag, " irq at completion"}, int'(irq), 1);
        chk(!bus_req, "R5", {tag, " request released"}, int'(bus_req), 0);
        chk(sb.size() == 0, "R2", {tag, " words left"}, sb.size(), 0);
        chk(req_rises == (single ? count : 1), single ? "R4" : "R3",
            {tag, " request rises"}, req_rises, single ? count : 1);
        chk(r1_viol == 0, "R1", {tag, " write without grant"}, r1_viol, 0);
        if (gdrop)
            chk(gnt_gaps > 0, "R10", {tag, " grant withdrawn"}, gnt_gaps, 1);
        if (poke) begin
            for (int i = 0; i < 10; i++) @(negedge clk);
            chk(req_rises == 1 && !bus_req, "R7", {tag, " no restart"}, req_rises, 1);
        end
        k_stall = 0; k_gaps = 0; k_gdrop = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !mem_valid && !irq, "R9", "reset outputs",
            int'({bus_req, mem_valid, irq}), 0);

        run_block(5, 6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "burst");

        // R6: clear bit 0 = 0 keeps irq, bit 0 = 1 clears it
        cfg_write(2'd3, 16'h0);
        @(negedge clk);
        chk(irq, "R6", "irq kept by null clear", int'(irq), 1);
        cfg_write(2'd3, 16'h1);
        @(negedge clk);
        chk(!irq, "R6", "irq cleared", int'(irq), 0);

        run_block(10, 4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "single");
        run_block(62, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "wrap");
        run_block(20, 12, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "gdrop");
        run_block(33, 8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "busy");
        run_block(3, 15, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "max-single");

        // R8: zero count
        cfg_write(2'd3, 16'h1);
        cfg_write(2'd1, 16'h0);
        req_rises = 0;
        cfg_write(2'd2, 16'h1);
        @(negedge clk);
        chk(irq, "R8", "zero count irq", int'(irq), 1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(req_rises == 0, "R8", "zero count request", req_rises, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule